// File: doc/BRIEF.md
# NOR Flash Command Sequencer with Suspend

This block turns host bus write cycles into flash operations on a small word array held inside it. The host writes command cycles, each an address and a data byte taken together with chip enable and write enable low. It can program a word, erase a sector, enter a short-form programming mode, and pause and restart an operation that is running. Program and erase times come from cycle counters. A program can only clear bits. A program that asks for a bit to go from 0 to 1 never finishes, and it ends in a timeout state.

While an operation runs, reads return a status byte instead of array data. Bit 7 is the inverse of bit 7 of the data being programmed, and it is 0 during an erase. Bit 6 flips on each read. Bit 5 flags a timeout. While an operation is paused, reads of other sectors return array data. Reads of the paused sector return status, with the toggle moved to bit 2. The ready output goes low for as long as an operation is running. The active-low reset aborts any operation without touching the array.

Top module: `nor_cmd_seq`

## Requirements
- R1: After the hardware reset (`rst_n` low), `ry_by_n` is 1 and the command decoder is idle. A program or erase that was running when reset came leaves the array unchanged.
- R2: Four writes program a word: 0xAA at 0x555, 0x55 at 0x2AA, 0xA0 at 0x555, then the data at the target address. After PROG_CYC cycles the word holds the old value ANDed with the data.
- R3: A write that does not match the expected address and data of an unlock or command cycle sends the decoder back to idle. A later lone data write then programs nothing.
- R4: Six writes erase a sector: 0xAA at 0x555, 0x55 at 0x2AA, 0x80 at 0x555, 0xAA at 0x555, 0x55 at 0x2AA, then 0x30 at any address in the sector. The sector is the top SEC_W address bits. After ERASE_CYC cycles every word in that sector reads all ones, and the other sectors keep their contents.
- R5: 0xAA at 0x555, 0x55 at 0x2AA, then 0x20 at 0x555 enter bypass mode. In bypass mode, 0xA0 followed by an address and data programs a word. 0x90 followed by 0x00 leaves bypass mode, and after that an 0xA0 and data pair programs nothing.
- R6: While an operation runs, a read at any address returns bit 7 equal to the inverse of programmed data bit 7. During an erase this bit is 0.
- R7: While an operation runs, status bit 6 has opposite values on consecutive reads.
- R8: `ry_by_n` goes low on the cycle after the final command write. It stays low for exactly PROG_CYC cycles for a program and ERASE_CYC cycles for an erase, then returns to 1.
- R9: 0xB0 written during a program pauses it, and `ry_by_n` is 1 on the next cycle. Reads of other sectors return array data. Reads of the paused sector return status with bit 7 still inverted, bit 6 held at 0 and bit 2 toggling. A write of 0x30 resumes the program, which then completes.
- R10: 0xB0 written during an erase pauses it. Reads of other sectors return array data. A program to another sector runs and completes. A program aimed at the paused sector is ignored and leaves `ry_by_n` at 1. A write of 0x30 resumes the erase.
- R11: If a program has not succeeded after MAX_CYC cycles, status bit 5 becomes 1 and `ry_by_n` stays low. A write of 0xF0 returns the block to read mode with the word unchanged.
- R12: While an operation runs, any write other than 0xB0 is ignored and leaves the command decoder state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hardware reset, active low, asynchronous |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low; one cycle low is one write |
| oe_n | input | 1 | Output enable, active low |
| addr | input | AW | Word address |
| wdata | input | DW | Write data / command byte |
| rdata | output | DW | Array data or status byte |
| ry_by_n | output | 1 | Low while a program or erase runs |

## Verification
The hardest state to reach is a program that runs nested inside a paused erase. It takes eleven correctly ordered writes, and the array contents must be known well enough to tell which sector each read touches. The stimulus first erases the whole array and tracks every word in a bench model. It then starts an erase, pauses it after a few cycles, and runs a program to another sector and a rejected program to the paused sector before resuming. The stimulus for the timeout deliberately requests a 0-to-1 bit change to reach the state where bit 5 is set.

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq #(
  parameter int AW = 11,
  parameter int DW = 8,
  parameter int SEC_W = 2,
  parameter int PROG_CYC = 6,
  parameter int ERASE_CYC = 24,
  parameter int MAX_CYC = 40,
  parameter logic [AW-1:0] UNLK_A1 = 'h555,
  parameter logic [AW-1:0] UNLK_A2 = 'h2AA
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          we_n,
  input  logic          oe_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          ry_by_n
);
  localparam int WORDS = 1 << AW;
  localparam int OFF_W = AW - SEC_W;
  localparam int SEC_WORDS = 1 << OFF_W;
  localparam int PCW = $clog2(MAX_CYC + 1);
  localparam int ECW = $clog2(ERASE_CYC + 1);
  localparam logic [PCW-1:0] P_END = PCW'(PROG_CYC - 1);
  localparam logic [PCW-1:0] T_END = PCW'(MAX_CYC - 1);
  localparam logic [ECW-1:0] E_END = ECW'(ERASE_CYC - 1);
  localparam logic [DW-1:0] K_AA = DW'(8'hAA);
  localparam logic [DW-1:0] K_55 = DW'(8'h55);
  localparam logic [DW-1:0] K_A0 = DW'(8'hA0);
  localparam logic [DW-1:0] K_80 = DW'(8'h80);
  localparam logic [DW-1:0] K_20 = DW'(8'h20);
  localparam logic [DW-1:0] K_30 = DW'(8'h30);
  localparam logic [DW-1:0] K_B0 = DW'(8'hB0);
  localparam logic [DW-1:0] K_90 = DW'(8'h90);
  localparam logic [DW-1:0] K_F0 = DW'(8'hF0);

  typedef enum logic [3:0] {
    C_IDLE, C_U1, C_U2, C_PGM, C_E1, C_E2, C_E3, C_BYP, C_BPGM, C_BEXIT
  } cmd_t;

  cmd_t              cmd_st;
  logic [DW-1:0]     mem [WORDS];
  logic              prog_act, psusp, fail;
  logic [AW-1:0]     prog_addr;
  logic [DW-1:0]     prog_data;
  logic [PCW-1:0]    prog_cnt;
  logic              ers_act, esusp;
  logic [SEC_W-1:0]  ers_sec;
  logic [ECW-1:0]    ers_cnt;
  logic              tog;
  logic [DW-1:0]     st;

  wire wr       = !ce_n && !we_n;
  wire rd       = !ce_n && !oe_n && we_n;
  wire [SEC_W-1:0] a_sec = addr[AW-1 -: SEC_W];
  wire prog_run = prog_act && !psusp && !fail;
  wire ers_run  = ers_act && !esusp;
  wire busy     = (prog_act && !psusp) || ers_run;
  wire pgm_ok   = (mem[prog_addr] & prog_data) == prog_data;
  wire p_done   = prog_run && prog_cnt == P_END && pgm_ok;
  wire e_done   = ers_run && ers_cnt == E_END;
  wire susp_hit = (psusp && a_sec == prog_addr[AW-1 -: SEC_W]) ||
                  (esusp && a_sec == ers_sec);
  wire show_st  = busy || susp_hit;
  wire pgm_deny = esusp && a_sec == ers_sec;

  assign ry_by_n = !busy;

  always_comb begin
    st    = '0;
    st[7] = prog_act ? ~prog_data[7] : 1'b0;
    st[6] = busy & tog;
    st[5] = fail;
    st[2] = !busy & tog;
  end

  assign rdata = show_st ? st : mem[addr];

  always_ff @(posedge clk) begin
    if (p_done) mem[prog_addr] <= prog_data;
    if (e_done)
      for (int j = 0; j < SEC_WORDS; j++) mem[{ers_sec, OFF_W'(j)}] <= '1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_st    <= C_IDLE;
      prog_act  <= 1'b0;
      psusp     <= 1'b0;
      fail      <= 1'b0;
      prog_addr <= '0;
      prog_data <= '0;
      prog_cnt  <= '0;
      ers_act   <= 1'b0;
      esusp     <= 1'b0;
      ers_sec   <= '0;
      ers_cnt   <= '0;
      tog       <= 1'b0;
    end else begin
      if (rd && show_st) tog <= ~tog;

      if (prog_run) begin
        if (p_done)                prog_act <= 1'b0;
        else if (prog_cnt == T_END) fail    <= 1'b1;
        else                        prog_cnt <= prog_cnt + 1'b1;
      end

      if (ers_run) begin
        if (e_done) ers_act <= 1'b0;
        else        ers_cnt <= ers_cnt + 1'b1;
      end

      if (wr) begin
        if (fail) begin
          if (wdata == K_F0) begin
            fail     <= 1'b0;
            prog_act <= 1'b0;
            prog_cnt <= '0;
          end
        end else if (prog_act && !psusp) begin
          if (wdata == K_B0 && !ers_act) psusp <= 1'b1;
        end else if (ers_run) begin
          if (wdata == K_B0) esusp <= 1'b1;
        end else if (psusp) begin
          if (wdata == K_30) psusp <= 1'b0;
        end else begin
          case (cmd_st)
            C_IDLE: begin
              if (addr == UNLK_A1 && wdata == K_AA) cmd_st <= C_U1;
              else if (esusp && wdata == K_30)      esusp  <= 1'b0;
            end
            C_U1: cmd_st <= (addr == UNLK_A2 && wdata == K_55) ? C_U2 : C_IDLE;
            C_U2: begin
              cmd_st <= C_IDLE;
              if (addr == UNLK_A1) begin
                if (wdata == K_A0)                 cmd_st <= C_PGM;
                else if (wdata == K_80 && !esusp)  cmd_st <= C_E1;
                else if (wdata == K_20 && !esusp)  cmd_st <= C_BYP;
              end
            end
            C_E1: cmd_st <= (addr == UNLK_A1 && wdata == K_AA) ? C_E2 : C_IDLE;
            C_E2: cmd_st <= (addr == UNLK_A2 && wdata == K_55) ? C_E3 : C_IDLE;
            C_E3: begin
              cmd_st <= C_IDLE;
              if (wdata == K_30) begin
                ers_act <= 1'b1;
                ers_sec <= a_sec;
                ers_cnt <= '0;
              end
            end
            C_PGM, C_BPGM: begin
              cmd_st <= (cmd_st == C_BPGM) ? C_BYP : C_IDLE;
              if (!pgm_deny) begin
                prog_act  <= 1'b1;
                prog_addr <= addr;
                prog_data <= wdata;
                prog_cnt  <= '0;
              end
            end
            C_BYP: begin
              if (wdata == K_A0)      cmd_st <= C_BPGM;
              else if (wdata == K_90) cmd_st <= C_BEXIT;
            end
            C_BEXIT: cmd_st <= (wdata == '0) ? C_IDLE : C_BYP;
            default: cmd_st <= C_IDLE;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/nor_cmd_seq_chk.sv
module nor_cmd_seq_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ce_n,
  input logic          we_n,
  input logic          oe_n,
  input logic [DW-1:0] wdata,
  input logic          rd_b6,
  input logic          rd_b5,
  input logic          ry_by_n,
  input logic          prog_act,
  input logic          psusp,
  input logic          fail,
  input logic          ers_act,
  input logic          esusp,
  input logic [3:0]    cmd_st
);
  localparam logic [DW-1:0] K_B0 = DW'(8'hB0);
  wire wr = !ce_n && !we_n;
  wire rd = !ce_n && !oe_n && we_n;

  p_reset_ready_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> ry_by_n);

  p_toggle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && !ry_by_n && $past(rd && !ry_by_n)) |-> rd_b6 != $past(rd_b6));

  p_psusp_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && wdata == K_B0 && prog_act && !psusp && !fail && !ers_act) |=> ry_by_n);

  p_esusp_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && wdata == K_B0 && ers_act && !esusp && !prog_act) |=> ry_by_n);

  p_fail_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    fail |-> !ry_by_n);

  p_fail_bit5_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && fail) |-> rd_b5);

  p_busy_ignore_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!ry_by_n && wr && wdata != K_B0 && !fail) |=> $stable(cmd_st));
endmodule

bind nor_cmd_seq nor_cmd_seq_chk #(.DW(DW)) i_chk (
  .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
  .wdata(wdata), .rd_b6(rdata[6]), .rd_b5(rdata[5]), .ry_by_n(ry_by_n),
  .prog_act(prog_act), .psusp(psusp), .fail(fail), .ers_act(ers_act),
  .esusp(esusp), .cmd_st(cmd_st)
);

// File: tb/test_nor_cmd_seq.sv
module test_nor_cmd_seq;
  localparam int AW = 11, DW = 8, SEC_W = 2;
  localparam int PROG_CYC = 6, ERASE_CYC = 24, MAX_CYC = 40;
  localparam int WORDS = 1 << AW;

  logic clk = 0, rst_n = 0, ce_n = 1, we_n = 1, oe_n = 1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0, rdata;
  logic ry_by_n;
  logic [7:0] model [WORDS];
  int n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  nor_cmd_seq #(.AW(AW), .DW(DW), .SEC_W(SEC_W), .PROG_CYC(PROG_CYC),
    .ERASE_CYC(ERASE_CYC), .MAX_CYC(MAX_CYC)) i_nor_cmd_seq (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .addr(addr), .wdata(wdata), .rdata(rdata), .ry_by_n(ry_by_n));

  function automatic logic [7:0] after_prog(input logic [7:0] old, input logic [7:0] d);
    return old & d;
  endfunction

  function automatic logic poll_bit(input logic [7:0] d);
    return ~d[7];
  endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    addr = a; wdata = d; ce_n = 0; we_n = 0;
    @(negedge clk);
    ce_n = 1; we_n = 1;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [7:0] v);
    addr = a; ce_n = 0; oe_n = 0;
    #1 v = rdata;
    @(negedge clk);
    ce_n = 1; oe_n = 1;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic unlock();
    wr(11'h555, 8'hAA); wr(11'h2AA, 8'h55);
  endtask

  task automatic prog4(input logic [AW-1:0] a, input logic [7:0] d);
    unlock(); wr(11'h555, 8'hA0); wr(a, d);
  endtask

  task automatic erase(input logic [SEC_W-1:0] s);
    unlock(); wr(11'h555, 8'h80); unlock(); wr({s, 9'h011}, 8'h30);
  endtask

  task automatic wait_ready();
    for (int i = 0; i < 2000 && !ry_by_n; i++) @(negedge clk);
  endtask

  task automatic erase_model(input logic [SEC_W-1:0] s);
    for (int i = 0; i < (1 << (AW - SEC_W)); i++) model[{s, 9'(i)}] = 8'hFF;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] v, v2, d;
    logic [AW-1:0] a;
    void'($urandom(32'd2718));
    idle(3);
    rst_n = 1;
    idle(1);
    chk(ry_by_n, 1, "R1 ready after reset");

    // initial erase of every sector; first one timed exactly
    erase(0);
    idle(ERASE_CYC - 1);
    chk(ry_by_n, 0, "R8 still busy at end of erase window");
    idle(1);
    chk(ry_by_n, 1, "R8 ready after erase window");
    for (int s = 1; s < 4; s++) begin erase(2'(s)); wait_ready(); end
    for (int s = 0; s < 4; s++) erase_model(2'(s));
    rd(11'h123, v); chk(v, 8'hFF, "R4 erased word");
    rd(11'h7FE, v); chk(v, 8'hFF, "R4 erased word top sector");

    // four-cycle program with polling and toggle
    d = after_prog(model[11'h010], 8'h5A);
    prog4(11'h010, d);
    rd(11'h300, v); rd(11'h300, v2);
    chk(v[7], poll_bit(d), "R6 data polling bit");
    chk(v[6] ^ v2[6], 1, "R7 toggle between reads");
    wait_ready();
    model[11'h010] = d;
    rd(11'h010, v); chk(v, model[11'h010], "R2 programmed word");

    d = after_prog(model[11'h020], 8'hC3);
    prog4(11'h020, d);
    idle(PROG_CYC - 1);
    chk(ry_by_n, 0, "R8 busy through program window");
    idle(1);
    chk(ry_by_n, 1, "R8 ready after program window");
    model[11'h020] = d;
    rd(11'h020, v); chk(v, d, "R2 timed program result");

    // wrong cycles
    wr(11'h555, 8'hAA); wr(11'h2AA, 8'h55); wr(11'h554, 8'hA0);
    wr(11'h030, 8'h00);
    chk(ry_by_n, 1, "R3 wrong command address starts nothing");
    rd(11'h030, v); chk(v, model[11'h030], "R3 word untouched after bad address");
    wr(11'h555, 8'hAA); wr(11'h2AA, 8'h56); wr(11'h555, 8'hA0);
    wr(11'h031, 8'h00);
    chk(ry_by_n, 1, "R3 wrong unlock data starts nothing");
    rd(11'h031, v); chk(v, model[11'h031], "R3 word untouched after bad unlock");

    // unlock bypass with random programs
    unlock(); wr(11'h555, 8'h20);
    for (int k = 0; k < 16; k++) begin
      a = AW'($urandom_range(0, WORDS - 1));
      d = after_prog(model[a], 8'($urandom));
      wr(11'h000, 8'hA0); wr(a, d);
      chk(ry_by_n, 0, "R5 bypass program starts");
      wait_ready();
      model[a] = d;
      rd(a, v); chk(v, d, "R5 bypass programmed word");
    end
    wr(11'h000, 8'h90); wr(11'h000, 8'h00);
    wr(11'h000, 8'hA0); wr(11'h040, 8'h00);
    chk(ry_by_n, 1, "R5 no program after bypass exit");
    rd(11'h040, v); chk(v, model[11'h040], "R5 word untouched after exit");

    // random normal programs and reads
    for (int k = 0; k < 16; k++) begin
      a = AW'($urandom_range(0, WORDS - 1));
      d = after_prog(model[a], 8'($urandom));
      prog4(a, d); wait_ready();
      model[a] = d;
    end
    for (int k = 0; k < 24; k++) begin
      a = AW'($urandom_range(0, WORDS - 1));
      rd(a, v); chk(v, model[a], "R2 random readback");
    end

    // program suspend
    d = after_prog(model[11'h101], 8'h0F);
    prog4(11'h101, d);
    idle(2);
    wr(11'h000, 8'hB0);
    chk(ry_by_n, 1, "R9 ready while program paused");
    rd(11'h405, v); chk(v, model[11'h405], "R9 other sector array read");
    rd(11'h101, v); rd(11'h101, v2);
    chk(v[7], poll_bit(d), "R9 paused sector polling bit");
    chk(v[6] | v2[6], 0, "R9 bit 6 held while paused");
    chk(v[2] ^ v2[2], 1, "R9 bit 2 toggles while paused");
    wr(11'h000, 8'h30);
    chk(ry_by_n, 0, "R9 resume makes busy");
    wait_ready();
    model[11'h101] = d;
    rd(11'h101, v); chk(v, d, "R9 program completes after resume");

    // erase suspend with nested program
    d = after_prog(model[11'h210], 8'h12);
    prog4(11'h210, d); wait_ready(); model[11'h210] = d;
    erase(1);
    idle(3);
    wr(11'h000, 8'hB0);
    chk(ry_by_n, 1, "R10 ready while erase paused");
    rd(11'h210, v); rd(11'h210, v2);
    chk(v[7], 0, "R6 erase polling bit is 0");
    chk(v[2] ^ v2[2], 1, "R10 paused sector shows toggling status");
    rd(11'h020, v); chk(v, model[11'h020], "R10 other sector array read");
    d = after_prog(model[11'h600], 8'hA5);
    prog4(11'h600, d);
    chk(ry_by_n, 0, "R10 nested program runs");
    wait_ready();
    model[11'h600] = d;
    rd(11'h600, v); chk(v, d, "R10 nested program result");
    prog4(11'h220, 8'h00);
    chk(ry_by_n, 1, "R10 program into paused sector ignored");
    wr(11'h000, 8'h30);
    chk(ry_by_n, 0, "R10 resume erase");
    wait_ready();
    erase_model(1);
    rd(11'h210, v); chk(v, 8'hFF, "R10 erase completed after resume");
    rd(11'h220, v); chk(v, 8'hFF, "R10 paused sector fully erased");
    rd(11'h600, v); chk(v, model[11'h600], "R4 other sector kept");

    // ignored writes while busy
    erase(2);
    unlock(); wr(11'h555, 8'hA0); wr(11'h000, 8'hF0);
    chk(ry_by_n, 0, "R12 busy after stray writes");
    wait_ready();
    erase_model(2);
    wr(11'h450, 8'h00);
    chk(ry_by_n, 1, "R12 stray sequence did not arm decoder");
    rd(11'h450, v); chk(v, 8'hFF, "R12 word untouched");

    // timeout
    d = ~model[11'h020];
    prog4(11'h020, d);
    idle(PROG_CYC + 2);
    rd(11'h100, v); chk(v[5], 0, "R11 no timeout yet");
    idle(MAX_CYC);
    chk(ry_by_n, 0, "R11 busy after timeout");
    rd(11'h100, v);
    chk(v[5], 1, "R11 timeout bit");
    chk(v[7], poll_bit(d), "R11 polling bit on failure");
    wr(11'h000, 8'hF0);
    chk(ry_by_n, 1, "R11 reset command clears");
    rd(11'h020, v); chk(v, model[11'h020], "R11 word unchanged");

    // hardware reset aborts
    prog4(11'h500, 8'h00);
    idle(2);
    rst_n = 0; idle(2); rst_n = 1;
    chk(ry_by_n, 1, "R1 reset aborts program");
    rd(11'h500, v); chk(v, model[11'h500], "R1 aborted program leaves word");
    erase(0);
    idle(5);
    rst_n = 0; idle(2); rst_n = 1;
    chk(ry_by_n, 1, "R1 reset aborts erase");
    rd(11'h010, v); chk(v, model[11'h010], "R1 aborted erase leaves word");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule